// File: doc/BRIEF.md
# Gated Edge-Count Frequency Meter

This block measures the frequency of an external digital input by counting its rising edges over a window of known length. Software picks a window length from a small select register. It then writes a command register to zero the count and open the window. It polls a one-bit status flag until the window has closed, and reads the count back as two bytes. The window length is a whole number of periods of a 1 kHz time-base tick supplied from outside. One select code keeps the window open with no time limit.

The input passes through a synchronizer and a rising-edge detector before it reaches the counter. The counter stops at its all-ones value instead of wrapping. When this happens the window keeps running until its programmed time is used up, so the status flag still tells software when the measurement period is over. Two low-power inputs change how the block behaves. Halt freezes every register at its current value. Stop returns every register to zero.

Top module: `gfc_top`

## Requirements
- R1: After reset, every readable address (0 command, 1 window select, 2 status, 3 count low byte, 4 count high byte) reads 0x00.
- R2: A write to address 0 with bit 0 set opens the window, and status bit 0 reads 1 from the next cycle. A write with bit 0 clear does not open the window.
- R3: A write to address 0 with bit 1 set zeroes the count and leaves the window state unchanged. When bits 0 and 1 are set in the same write, the count is zeroed and the window opens.
- R4: Bits 7:2 of the command register are ignored when written. Status bits 7:1 and window-select bits 7:2 always read 0.
- R5: For window-select codes 0, 1 and 2 (bits 1:0 at address 1), the window closes on the 1st, 4th and 8th tick after the start command. The count of ticks restarts at the start command.
- R6: With window-select code 3, the window stays open no matter how many ticks arrive.
- R7: While the window is open, each rising edge of the input adds one to the count. Edges that arrive while the window is closed are ignored. The count reads as a low byte at address 3 and a high byte at address 4.
- R8: The count stops at 2^CNT_W-1 and does not wrap. Status bit 0 stays 1 until the window's tick count has run out.
- R9: A start command issued while the window is open reloads the full window time.
- R10: While halt is high, all register contents are held. Bus writes, ticks and input edges have no effect.
- R11: A stop pulse returns the count, the window state and the window select to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Low-power hold: freezes all state |
| stop_i | input | 1 | Low-power stop: returns all state to zero |
| tick_i | input | 1 | Single-cycle 1 kHz time-base pulse |
| sig_i | input | 1 | Signal whose edges are counted (asynchronous) |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |

## Verification
The assertions assume that the tick input is high for only one clock cycle at a time. They also assume that stop takes priority over halt, and that a start command changes the window state only when neither low-power input is active. The bench keeps each input level steady for at least one full clock period. It pulses the tick for exactly one cycle, and it raises halt or stop only between bus transactions. This keeps the synchronizer latency and the window boundaries deterministic when results are sampled at the falling edge.

// File: rtl/gfc_pkg.sv
package gfc_pkg;

   typedef enum logic [1:0] {
      GSEL_SHORT  = 2'd0,
      GSEL_MID    = 2'd1,
      GSEL_LONG   = 2'd2,
      GSEL_UNLIM  = 2'd3
   } gsel_e;

   localparam int unsigned ADR_CMD   = 0;
   localparam int unsigned ADR_GSEL  = 1;
   localparam int unsigned ADR_STAT  = 2;
   localparam int unsigned ADR_CNTL  = 3;
   localparam int unsigned ADR_CNTH  = 4;

   localparam int unsigned CMD_START_BIT = 0;
   localparam int unsigned CMD_CLEAR_BIT = 1;

endpackage

// File: rtl/gfc_sync_edge.sv
module gfc_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst_i,
   input  logic hold_i,
   input  logic sig_i,
   output logic rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gfc_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   // chain_q[0] is the first synchronizer flop, chain_q[STAGES-1] the
   // resolved level, chain_q[STAGES] the level one cycle earlier.
   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (srst_i) begin
         chain_q <= '0;
      end else if (!hold_i) begin
         chain_q <= {chain_q[STAGES-1:0], sig_i};
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES] & ~hold_i;

   // R7: a single input edge is seen as a single-cycle pulse
   p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o)
      else $error("p_rise_single_r7");

endmodule

// File: rtl/gfc_gate_timer.sv
module gfc_gate_timer
   import gfc_pkg::*;
#(
   parameter int unsigned SHORT_TICKS = 1,
   parameter int unsigned MID_TICKS   = 4,
   parameter int unsigned LONG_TICKS  = 8
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  srst_i,
   input  logic  hold_i,
   input  logic  start_i,
   input  gsel_e sel_i,
   input  logic  tick_i,
   output logic  open_o
);

   localparam int unsigned MAX_A = (SHORT_TICKS > MID_TICKS) ? SHORT_TICKS : MID_TICKS;
   localparam int unsigned MAX_T = (MAX_A > LONG_TICKS) ? MAX_A : LONG_TICKS;
   localparam int unsigned TW    = $clog2(MAX_T + 1);

   generate
      if (SHORT_TICKS < 1 || MID_TICKS < 1 || LONG_TICKS < 1) begin : g_bad_ticks
         $error("gfc_gate_timer: every window needs at least one tick");
      end
   endgenerate

   function automatic logic [TW-1:0] window_len(gsel_e s);
      case (s)
         GSEL_SHORT: window_len = TW'(SHORT_TICKS);
         GSEL_MID:   window_len = TW'(MID_TICKS);
         GSEL_LONG:  window_len = TW'(LONG_TICKS);
         default:    window_len = '0;
      endcase
   endfunction

   logic [TW-1:0] left_q;
   logic          open_q;
   logic          unlim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q  <= '0;
         open_q  <= 1'b0;
         unlim_q <= 1'b0;
      end else if (srst_i) begin
         left_q  <= '0;
         open_q  <= 1'b0;
         unlim_q <= 1'b0;
      end else if (!hold_i) begin
         if (start_i) begin
            open_q  <= 1'b1;
            left_q  <= window_len(sel_i);
            unlim_q <= (sel_i == GSEL_UNLIM);
         end else if (open_q && !unlim_q && tick_i) begin
            if (left_q <= TW'(1)) begin
               open_q <= 1'b0;
               left_q <= '0;
            end else begin
               left_q <= left_q - TW'(1);
            end
         end
      end
   end

   assign open_o = open_q;

   // R2: a start opens the window on the next edge
   p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !srst_i && !hold_i) |=> open_q)
      else $error("p_start_opens_r2");

   // R5: the window only closes on a tick
   p_close_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && !tick_i && !srst_i) |=> open_q)
      else $error("p_close_on_tick_r5");

   // R6: an unlimited window never closes by itself
   p_unlim_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && unlim_q && !srst_i) |=> open_q)
      else $error("p_unlim_stays_r6");

endmodule

// File: rtl/gfc_counter.sv
module gfc_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst_i,
   input  logic         hold_i,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_width
         $error("gfc_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (srst_i) begin
         cnt_q <= '0;
      end else if (!hold_i) begin
         if (clr_i) begin
            cnt_q <= '0;
         end else if (inc_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + W'(1);
         end
      end
   end

   assign cnt_o = cnt_q;

   // R3: clear wins over any increment in the same cycle
   p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hold_i) |=> (cnt_q == '0))
      else $error("p_clear_zero_r3");

   // R8: a full counter stays full
   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !clr_i && !srst_i) |=> (cnt_q == CNT_MAX))
      else $error("p_sat_hold_r8");

   // R7: the count moves up by at most one per cycle
   p_single_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !srst_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)))
      else $error("p_single_step_r7");

endmodule

// File: rtl/gfc_top.sv
module gfc_top
   import gfc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SHORT_TICKS = 1,
   parameter int unsigned MID_TICKS   = 4,
   parameter int unsigned LONG_TICKS  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic              stop_i,
   input  logic              tick_i,
   input  logic              sig_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o
);

   localparam int unsigned WIDE_W = 16;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("gfc_top: ADDR_W must reach address 4");
      end
      if (CNT_W < 9 || CNT_W > WIDE_W) begin : g_bad_cnt
         $error("gfc_top: CNT_W must lie in 9..16");
      end
   endgenerate

   logic             wr_ok;
   logic             cmd_wr;
   logic             start_cmd;
   logic             clear_cmd;
   logic             hold;
   gsel_e            gsel_q;
   logic             rise;
   logic             gate_open;
   logic [CNT_W-1:0] cnt;
   logic [WIDE_W-1:0] cnt_wide;

   assign hold      = halt_i & ~stop_i;
   assign wr_ok     = bus_wr_i & ~halt_i & ~stop_i;
   assign cmd_wr    = wr_ok && (bus_addr_i == ADDR_W'(ADR_CMD));
   assign start_cmd = cmd_wr & bus_wdata_i[CMD_START_BIT];
   assign clear_cmd = cmd_wr & bus_wdata_i[CMD_CLEAR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gsel_q <= GSEL_SHORT;
      end else if (stop_i) begin
         gsel_q <= GSEL_SHORT;
      end else if (wr_ok && bus_addr_i == ADDR_W'(ADR_GSEL)) begin
         gsel_q <= gsel_e'(bus_wdata_i[1:0]);
      end
   end

   gfc_sync_edge #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst_i (stop_i),
      .hold_i (hold),
      .sig_i  (sig_i),
      .rise_o (rise)
   );

   gfc_gate_timer #(
      .SHORT_TICKS (SHORT_TICKS),
      .MID_TICKS   (MID_TICKS),
      .LONG_TICKS  (LONG_TICKS)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst_i  (stop_i),
      .hold_i  (hold),
      .start_i (start_cmd),
      .sel_i   (gsel_q),
      .tick_i  (tick_i),
      .open_o  (gate_open)
   );

   gfc_counter #(
      .W (CNT_W)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .srst_i (stop_i),
      .hold_i (hold),
      .clr_i  (clear_cmd),
      .inc_i  (rise & gate_open),
      .cnt_o  (cnt)
   );

   assign cnt_wide = WIDE_W'(cnt);

   always_comb begin
      bus_rdata_o = 8'h00;
      case (bus_addr_i)
         ADDR_W'(ADR_GSEL): bus_rdata_o = {6'b0, gsel_q};
         ADDR_W'(ADR_STAT): bus_rdata_o = {7'b0, gate_open};
         ADDR_W'(ADR_CNTL): bus_rdata_o = cnt_wide[7:0];
         ADDR_W'(ADR_CNTH): bus_rdata_o = cnt_wide[15:8];
         default:           bus_rdata_o = 8'h00;
      endcase
   end

   // R10: halt freezes every register
   p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_i && !stop_i) |=> ($stable(cnt) && $stable(gate_open) && $stable(gsel_q)))
      else $error("p_halt_freeze_r10");

   // R11: stop returns all state to zero
   p_stop_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (cnt == '0 && !gate_open && gsel_q == GSEL_SHORT))
      else $error("p_stop_zero_r11");

   // R4: a command write carrying only pad bits changes nothing
   p_pad_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && bus_wdata_i[1:0] == 2'b00 && bus_wdata_i[7:2] != 6'b0 && !tick_i && !rise)
      |=> ($stable(cnt) && $stable(gate_open)))
      else $error("p_pad_ignored_r4");

endmodule

// File: tb/gfc_top_tb.sv
module gfc_top_tb;
   import gfc_pkg::*;

   localparam int unsigned CW = 10;
   localparam logic [15:0] CNT_FULL = 16'((1 << CW) - 1);

   typedef struct packed {
      logic [1:0]  sel;
      logic [7:0]  pulses;
      logic [7:0]  ticks;
      logic [15:0] exp_cnt;
      logic        exp_open;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'd5, 8'd0,  16'd5, 1'b1},
      '{2'd0, 8'd7, 8'd1,  16'd7, 1'b0},
      '{2'd1, 8'd3, 8'd3,  16'd3, 1'b1},
      '{2'd1, 8'd4, 8'd4,  16'd4, 1'b0},
      '{2'd2, 8'd9, 8'd7,  16'd9, 1'b1},
      '{2'd2, 8'd2, 8'd8,  16'd2, 1'b0},
      '{2'd3, 8'd6, 8'd20, 16'd6, 1'b1},
      '{2'd1, 8'd0, 8'd2,  16'd0, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       halt = 1'b0;
   logic       stop = 1'b0;
   logic       tick = 1'b0;
   logic       sig = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gfc_top #(
      .CNT_W (CW)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_i      (halt),
      .stop_i      (stop),
      .tick_i      (tick),
      .sig_i       (sig),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int unsigned a, input logic [7:0] d);
      @(negedge clk);
      addr  = 3'(a);
      wdata = d;
      wr    = 1'b1;
      @(negedge clk);
      wr    = 1'b0;
   endtask

   task automatic bus_rd(input int unsigned a, output logic [7:0] d);
      @(negedge clk);
      addr = 3'(a);
      #1;
      d = rdata;
   endtask

   task automatic rd_count(output logic [15:0] c);
      logic [7:0] lo;
      logic [7:0] hi;
      bus_rd(ADR_CNTL, lo);
      bus_rd(ADR_CNTH, hi);
      c = {hi, lo};
   endtask

   task automatic pulse();
      @(negedge clk);
      sig = 1'b1;
      repeat (2) @(negedge clk);
      sig = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic give_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] c;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state on every address
      for (int a = 0; a <= 4; a++) begin
         bus_rd(a, b);
         check("R1", 16'(b), 16'h0);
      end

      // Table walk: R5, R6, R7
      for (int i = 0; i < NV; i++) begin
         bus_wr(ADR_GSEL, {6'b0, VECS[i].sel});
         bus_wr(ADR_CMD, 8'h03);
         for (int p = 0; p < int'(VECS[i].pulses); p++) pulse();
         for (int t = 0; t < int'(VECS[i].ticks); t++) give_tick();
         rd_count(c);
         check("R7", c, VECS[i].exp_cnt);
         bus_rd(ADR_STAT, b);
         check((VECS[i].sel == 2'd3) ? "R6" : "R5", 16'(b), 16'(VECS[i].exp_open));
         repeat (2) pulse();
         rd_count(c);
         check("R7", c, VECS[i].exp_cnt + (VECS[i].exp_open ? 16'd2 : 16'd0));
      end

      // R2: start bit clear does not open the window
      bus_wr(ADR_GSEL, 8'h00);
      bus_wr(ADR_CMD, 8'h03);
      give_tick();
      bus_wr(ADR_CMD, 8'h00);
      bus_rd(ADR_STAT, b);
      check("R2", 16'(b), 16'h0);

      // R4: pad bits of command ignored, status and select pads read 0
      bus_wr(ADR_CMD, 8'hFC);
      bus_rd(ADR_STAT, b);
      check("R4", 16'(b), 16'h0);
      rd_count(c);
      check("R4", c, 16'h0);
      bus_wr(ADR_GSEL, 8'hFF);
      bus_rd(ADR_GSEL, b);
      check("R4", 16'(b), 16'h03);

      // R3: clear alone zeroes count, window unaffected
      bus_wr(ADR_CMD, 8'h03);
      repeat (5) pulse();
      bus_wr(ADR_CMD, 8'h02);
      rd_count(c);
      check("R3", c, 16'h0);
      bus_rd(ADR_STAT, b);
      check("R3", 16'(b), 16'h1);
      repeat (3) pulse();
      bus_wr(ADR_CMD, 8'h03);
      rd_count(c);
      check("R3", c, 16'h0);

      // R9: restart reloads the window
      bus_wr(ADR_GSEL, 8'h01);
      bus_wr(ADR_CMD, 8'h03);
      repeat (3) give_tick();
      bus_wr(ADR_CMD, 8'h01);
      repeat (3) give_tick();
      bus_rd(ADR_STAT, b);
      check("R9", 16'(b), 16'h1);
      give_tick();
      bus_rd(ADR_STAT, b);
      check("R9", 16'(b), 16'h0);

      // R8: saturation, window keeps running
      bus_wr(ADR_GSEL, 8'h02);
      bus_wr(ADR_CMD, 8'h03);
      for (int p = 0; p < (1 << CW) + 8; p++) begin
         @(negedge clk);
         sig = 1'b1;
         @(negedge clk);
         sig = 1'b0;
      end
      repeat (4) @(negedge clk);
      rd_count(c);
      check("R8", c, CNT_FULL);
      repeat (7) give_tick();
      bus_rd(ADR_STAT, b);
      check("R8", 16'(b), 16'h1);
      give_tick();
      bus_rd(ADR_STAT, b);
      check("R8", 16'(b), 16'h0);

      // R10: halt holds everything
      bus_wr(ADR_GSEL, 8'h01);
      bus_wr(ADR_CMD, 8'h03);
      repeat (2) pulse();
      @(negedge clk);
      halt = 1'b1;
      repeat (4) give_tick();
      repeat (3) pulse();
      bus_wr(ADR_CMD, 8'h02);
      bus_wr(ADR_GSEL, 8'h02);
      rd_count(c);
      check("R10", c, 16'd2);
      bus_rd(ADR_STAT, b);
      check("R10", 16'(b), 16'h1);
      bus_rd(ADR_GSEL, b);
      check("R10", 16'(b), 16'h1);
      @(negedge clk);
      halt = 1'b0;
      repeat (4) give_tick();
      bus_rd(ADR_STAT, b);
      check("R10", 16'(b), 16'h0);
      rd_count(c);
      check("R10", c, 16'd2);

      // R11: stop clears all registers
      bus_wr(ADR_GSEL, 8'h02);
      bus_wr(ADR_CMD, 8'h03);
      repeat (3) pulse();
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      rd_count(c);
      check("R11", c, 16'h0);
      bus_rd(ADR_STAT, b);
      check("R11", 16'(b), 16'h0);
      bus_rd(ADR_GSEL, b);
      check("R11", 16'(b), 16'h0);

      report();
      $finish;
   end

endmodule